// File: doc/BRIEF.md
# SPI Configuration Register Write Port

This block is a write-only SPI target that lets a host controller load a bank of 8-bit configuration registers. The chip-select, serial-clock and serial-data pins are treated as fully asynchronous. They are resynchronised into a fast system clock, and their edges are found by comparing successive samples. Each frame opens with a 7-bit device identifier and a direction bit. A pointer byte follows, and then any number of data bytes. Every completed data byte produces a single-cycle write strobe that carries the register address and the data. Register storage lives outside the block.

A flag records that the serial control mode is in use. The first falling edge seen on chip select after reset sets it, and only a reset clears it. Neighbouring logic uses this flag to choose between control-port personalities.

Top module: `cfg_spi_wr_port`

## Requirements
- R1: A frame is active while `sel_n` is low. Serial data is taken on each rising edge of `sclk`, most significant bit first, in groups of 8 bits.
- R2: The first byte of a frame carries the device identifier in bits 7:1, and that identifier must equal 7'b0010000. On any other value, the rest of the frame produces no write.
- R3: Bit 0 of the first byte gives the direction, with 0 meaning write. When this bit is 1, the frame produces no write.
- R4: The second byte is the pointer, and its bits 6:0 select the register. Each later complete byte produces a write of that byte to the selected register, reported on `wr_addr` and `wr_data`.
- R5: When bit 7 of the pointer byte is 1, the register address rises by one after each data byte. It wraps from 127 to 0.
- R6: When bit 7 of the pointer byte is 0, every data byte in the frame goes to the same register.
- R7: `spi_mode` is 0 after reset. It becomes 1 after the first high-to-low transition of `sel_n`, and it stays at 1 until the next reset.
- R8: Raising `sel_n` at any point ends the frame. A partly received byte is discarded, and the next frame starts again with the device-identifier byte.
- R9: `wr_stb` is high for exactly one system-clock cycle per data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial bit clock, asynchronous |
| sdi | input | 1 | Serial data in |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register address for the write |
| wr_data | output | 8 | Data byte for the write |
| spi_mode | output | 1 | Sticky flag for serial control mode |

## Verification
The hardest situations to reach from the ports are an abort that lands part-way through a byte, and a frame that follows that abort. Both require chip select to rise between two serial-clock edges while the bit counter sits at a non-zero value. The bench drives whole bytes followed by a chosen number of trailing bits, then raises chip select. It then sends a clean frame at once and expects exactly the writes that the clean frame alone would produce. Pointer wrap-around is reached by starting an auto-increment burst at address 125. Every device identifier and every register address is swept.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  typedef enum logic [1:0] {
    PH_DEV  = 2'd0,
    PH_PTR  = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], din[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign dout[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/cfg_spi_edges.sv
module cfg_spi_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n_s,
  input  logic sclk_s,
  output logic sel_fall,
  output logic sclk_rise,
  output logic mode
);
  logic sel_prev_q, sclk_prev_q, mode_q, mode_d;

  always_comb begin
    sel_fall  = sel_prev_q & ~sel_n_s;
    sclk_rise = ~sclk_prev_q & sclk_s;
    mode_d    = mode_q | sel_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q  <= 1'b0;
      sclk_prev_q <= 1'b0;
      mode_q      <= 1'b0;
    end else begin
      sel_prev_q  <= sel_n_s;
      sclk_prev_q <= sclk_s;
      mode_q      <= mode_d;
    end
  end

  assign mode = mode_q;

  // R7: once selected, serial mode is never dropped without reset
  assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> mode_q);
  // R7: the flag only rises on a chip-select fall
  assert_mode_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !sel_fall) |=> !mode_q);
endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
  import cfg_spi_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          AW       = 7,
  parameter logic [DW-2:0] DEV_ID = 7'b0010000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_idle,
  input  logic          sclk_rise,
  input  logic          sdi_s,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int CW = $clog2(DW);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-2:0] shf_q, shf_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          incr_q, incr_d;
  logic          stb_q, stb_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] byte_w;
  logic          last_bit;

  always_comb begin
    byte_w   = {shf_q, sdi_s};
    last_bit = (cnt_q == CW'(DW - 1));
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    shf_d    = shf_q;
    ptr_d    = ptr_q;
    incr_d   = incr_q;
    stb_d    = 1'b0;
    if (sel_idle) begin
      phase_d = PH_DEV;
      cnt_d   = '0;
    end else if (sclk_rise) begin
      shf_d = byte_w[DW-2:0];
      cnt_d = last_bit ? '0 : cnt_q + 1'b1;
      if (last_bit) begin
        unique case (phase_q)
          PH_DEV:  phase_d = (byte_w[DW-1:1] == DEV_ID && !byte_w[0]) ? PH_PTR : PH_SKIP;
          PH_PTR: begin
            ptr_d   = byte_w[AW-1:0];
            incr_d  = byte_w[DW-1];
            phase_d = PH_DATA;
          end
          PH_DATA: begin
            stb_d = 1'b1;
            if (incr_q) ptr_d = ptr_q + 1'b1;
          end
          PH_SKIP: phase_d = PH_SKIP;
          default: phase_d = PH_SKIP;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DEV;
      cnt_q   <= '0;
      shf_q   <= '0;
      ptr_q   <= '0;
      incr_q  <= 1'b0;
      stb_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      shf_q   <= shf_d;
      ptr_q   <= ptr_d;
      incr_q  <= incr_d;
      stb_q   <= stb_d;
      if (stb_d) begin
        addr_q <= ptr_q;
        data_q <= byte_w;
      end
    end
  end

  assign wr_stb  = stb_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;

  // R8: an idle chip select returns the frame to the identifier phase
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_idle |=> (phase_q == PH_DEV && cnt_q == '0));
  // R9: strobe never lasts two cycles
  assert_stb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  // R4: writes only come out of the data phase
  assert_stb_in_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> phase_q == PH_DATA);
  // R5: pointer has advanced past the reported address
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && incr_q) |-> ptr_q == AW'(addr_q + 1'b1));
  // R6: pointer unchanged when increment is off
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && !incr_q) |-> ptr_q == addr_q);
endmodule

// File: rtl/cfg_spi_wr_port.sv
module cfg_spi_wr_port #(
  parameter int           SYNC_STAGES = 2,
  parameter int           DW          = 8,
  parameter int           AW          = 7,
  parameter logic [DW-2:0] DEV_ID     = 7'b0010000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          sclk,
  input  logic          sdi,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          spi_mode
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic [2:0] pins_s;
  logic       sel_fall, sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  cfg_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  ({sdi, sclk, sel_n}),
    .dout (pins_s)
  );

  cfg_spi_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel_n_s  (pins_s[0]),
    .sclk_s   (pins_s[1]),
    .sel_fall (sel_fall),
    .sclk_rise(sclk_rise),
    .mode     (spi_mode)
  );

  cfg_spi_frame #(.DW(DW), .AW(AW), .DEV_ID(DEV_ID)) u_frame (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel_idle (pins_s[0]),
    .sclk_rise(sclk_rise),
    .sdi_s    (pins_s[2]),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );
endmodule

// File: tb/tb_cfg_spi_wr_port.sv
module tb_cfg_spi_wr_port;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic       wr_stb;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic       spi_mode;

  always #2.5 clk = ~clk;

  cfg_spi_wr_port dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .spi_mode(spi_mode)
  );

  int checks = 0;
  int fails = 0;
  int cap_tot = 0;
  int dbl_cnt = 0;
  logic prev_stb = 1'b0;
  logic [6:0] cap_a [256];
  logic [7:0] cap_d [256];
  logic [7:0] tx [16];
  int tx_n = 0;
  int tail = 0;

  always @(negedge clk) begin
    if (wr_stb) begin
      cap_a[cap_tot[7:0]] <= wr_addr;
      cap_d[cap_tot[7:0]] <= wr_data;
      cap_tot <= cap_tot + 1;
    end
    if (wr_stb && prev_stb) dbl_cnt <= dbl_cnt + 1;
    prev_stb <= wr_stb;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) sdi = b;
    tick(3);
    @(negedge clk) sclk = 1'b1;
    tick(3);
    @(negedge clk) sclk = 1'b0;
  endtask

  task automatic send_frame();
    @(negedge clk) sel_n = 1'b0;
    tick(3);
    for (int i = 0; i < tx_n; i++)
      for (int j = 7; j >= 0; j--) send_bit(tx[i][j]);
    for (int k = 0; k < tail; k++) send_bit(tx[tx_n][7-k]);
    tick(6);
    @(negedge clk) sel_n = 1'b1;
    tick(8);
  endtask

  // Expected writes follow R2..R6 and R8 from the bytes sent
  task automatic run_frame(input string req);
    int start, nexp;
    logic ok_hdr, inc;
    logic [6:0] base, ea;
    start  = cap_tot;
    send_frame();
    ok_hdr = (tx_n >= 1) && (tx[0][7:1] == 7'b0010000) && !tx[0][0];
    nexp   = (ok_hdr && tx_n >= 2) ? tx_n - 2 : 0;
    inc    = tx[1][7];
    base   = tx[1][6:0];
    check(cap_tot - start == nexp, req, cap_tot - start, nexp);
    for (int k = 0; k < nexp && k == cap_tot - start - (cap_tot - start - k); k++) begin
      if (k >= cap_tot - start) break;
      ea = inc ? 7'(base + k) : base;
      check(cap_a[(start + k) % 256] == ea, req, int'(cap_a[(start + k) % 256]), int'(ea));
      check(cap_d[(start + k) % 256] == tx[k + 2], req, int'(cap_d[(start + k) % 256]), int'(tx[k + 2]));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tick(5);
    @(negedge clk) rst_n = 1'b1;
    tick(10);
    @(negedge clk);
    check(wr_stb == 1'b0, "R9 reset strobe", int'(wr_stb), 0);
    check(spi_mode == 1'b0, "R7 reset mode", int'(spi_mode), 0);

    // R4 R6 R1: single write to every register, MSB-first data pattern
    for (int a = 0; a < 128; a++) begin
      tx[0] = 8'h20; tx[1] = 8'(a); tx[2] = 8'(a * 3 + 5); tx_n = 3; tail = 0;
      run_frame("R4");
      if (a == 0) check(spi_mode == 1'b1, "R7 mode set", int'(spi_mode), 1);
    end

    // R5: auto-increment burst crossing the top address
    tx[0] = 8'h20; tx[1] = 8'h80 | 8'd125;
    for (int k = 0; k < 5; k++) tx[k + 2] = 8'(8'hA0 + k);
    tx_n = 7; tail = 0;
    run_frame("R5");

    // R6: burst with increment off
    tx[0] = 8'h20; tx[1] = 8'd9;
    for (int k = 0; k < 4; k++) tx[k + 2] = 8'(8'h5A ^ (k * 17));
    tx_n = 6; tail = 0;
    run_frame("R6");

    // R2: every wrong device identifier
    for (int d = 0; d < 128; d++) begin
      if (d == 7'b0010000) continue;
      tx[0] = 8'({d[6:0], 1'b0}); tx[1] = 8'd3; tx[2] = 8'h77; tx_n = 3; tail = 0;
      run_frame("R2");
    end

    // R3: read direction produces no write
    tx[0] = 8'h21; tx[1] = 8'd4; tx[2] = 8'h11; tx[3] = 8'h22; tx_n = 4; tail = 0;
    run_frame("R3");

    // R8: aborts at various bit positions, each followed by a clean frame
    for (int t = 1; t < 8; t++) begin
      tx[0] = 8'h20; tx[1] = 8'd40; tx[2] = 8'hFF; tx_n = 2; tail = t;
      run_frame("R8 abort data");
      tx[0] = 8'h20; tx_n = 0; tail = t;
      run_frame("R8 abort id");
      tx[0] = 8'h20; tx[1] = 8'(t); tx[2] = 8'(8'hC0 + t); tx_n = 3; tail = 0;
      run_frame("R8 recover");
    end

    check(dbl_cnt == 0, "R9 single cycle", dbl_cnt, 0);
    check(spi_mode == 1'b1, "R7 mode held", int'(spi_mode), 1);
    @(negedge clk) rst_n = 1'b0;
    tick(3);
    @(negedge clk) rst_n = 1'b1;
    tick(6);
    @(negedge clk);
    check(spi_mode == 1'b0, "R7 mode cleared", int'(spi_mode), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule